// File: doc/BRIEF.md
# CEC Receive Frame Triple Buffer

This block sits behind a bit-level CEC receiver and holds up to three completed frames until software collects them. The receiver delivers one byte per `rx_valid` pulse and flags the final byte of a frame with `rx_eof`. Incoming bytes go into a staging area. When a frame ends, it is copied whole into the lowest-numbered empty buffer. That buffer then raises its own ready line and receives an age rank.

Software reads a single status byte that packs the three ranks. From it, software can drain the buffers oldest first. To release a buffer, software sets that buffer's release bit in the control register and then clears it. When a buffer is released, every younger buffer moves up one rank, so the ranks stay contiguous. A mode bit restricts reception to buffer 0 for a single-buffer arrangement. A sticky flag records any frame that was dropped because no slot was free.

Top module: `cec_rx_tribuf`

## Requirements
- R1: A completed frame is stored in the lowest-index buffer that is empty at completion. Buffer b's byte k reads at address 16*b+k, with the header byte at k=0.
- R2: The length register of buffer b (address 0x30+b) reads the stored byte count, header included, in bits [4:0]. It reads 0 when the buffer is empty.
- R3: A frame of more than 16 bytes is stored as its first 16 bytes with a length of 16.
- R4: The status byte at 0x33 holds buffer b's rank in bits [2b+1:2b]. Rank 0 means empty, and ranks 1/2/3 mean oldest, middle and newest. A new frame takes rank (occupied count + 1).
- R5: Releasing a buffer lowers the rank of every buffer that ranked above it by one, and leaves the lower-ranked buffers unchanged.
- R6: Control register 0x34 bits [2:0] are the per-buffer release bits. A buffer is released only when its bit is written from 1 to 0, and it stays occupied while the bit is held at 1.
- R7: Writing 0x0F and then 0x08 to the control register empties all three buffers and leaves mode bit 3 set.
- R8: A frame that completes when no permitted buffer is empty is discarded and leaves all stored buffers unchanged. The frame sets overflow flag bit 4 of the control register, and that flag stays set until a control write with bit 4 = 1 clears it.
- R9: With control bit 3 = 0 (the reset value), only buffer 0 may receive. A frame that arrives while buffer 0 is full is dropped as described in R8. With bit 3 = 1, all three buffers may receive.
- R10: `rx_ready[b]` is high exactly while buffer b holds a frame.
- R11: After reset, all buffers are empty, `rx_ready` is 0, and the status and control registers read 0.
- R12: Byte addresses at or past a buffer's stored length, and all bytes of an empty buffer, read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | One received byte is present this cycle |
| rx_byte | input | 8 | Received byte |
| rx_eof | input | 1 | This byte ends the frame (qualified by rx_valid) |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from reg_addr) |
| rx_ready | output | 3 | Per-buffer ready interrupt |

## Verification
A corrupted rank shows up in the status byte within one cycle: either two occupied buffers carry the same rank, or the ranks no longer run contiguously from 1. An occupancy bit that drifts away from its rank makes `rx_ready` disagree with the status byte in the same cycle. A wrong length shows up as nonzero bytes past the frame end, or as missing tail bytes. The bench uses release sequences that remove the oldest, a middle and every buffer, so any error in rank compaction reaches the status byte on the next read.

// File: rtl/cec_rx_tribuf.sv
module cec_rx_tribuf #(
  parameter int NBUF    = 3,
  parameter int MAX_LEN = 16,
  parameter int DW      = 8,
  parameter int AW      = 6,
  parameter int LEN_W   = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_byte,
  input  logic          rx_eof,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic [NBUF-1:0] rx_ready
);
  localparam int IDX_W     = $clog2(MAX_LEN);
  localparam int SLOT_W    = $clog2(NBUF);
  localparam int RANK_W    = 2;
  localparam int LEN_BASE  = NBUF * MAX_LEN;
  localparam int STAT_ADDR = LEN_BASE + NBUF;
  localparam int CTRL_ADDR = STAT_ADDR + 1;
  localparam int MODE_BIT  = NBUF;
  localparam int OVF_BIT   = NBUF + 1;

  logic [DW-1:0] stg [MAX_LEN];
  logic [LEN_W-1:0] stg_cnt;
  logic [DW-1:0] mem [NBUF][MAX_LEN];

  logic [NBUF-1:0] occ, occ_f, clr_q, cand, allow, free_mask;
  logic [NBUF-1:0][RANK_W-1:0] rank, rank_f;
  logic [NBUF-1:0][LEN_W-1:0]  len;
  logic [RANK_W-1:0] n_occ;
  logic [SLOT_W-1:0] slot;
  logic mode, ovf, has_slot;

  wire room       = stg_cnt < LEN_W'(MAX_LEN);
  wire frame_done = rx_valid & rx_eof;
  wire [LEN_W-1:0] fin_len = room ? stg_cnt + LEN_W'(1) : stg_cnt;
  wire ctrl_wr    = reg_we && reg_addr == AW'(CTRL_ADDR);
  wire take       = frame_done & has_slot;
  wire drop       = frame_done & ~has_slot;

  assign free_mask = ctrl_wr ? (clr_q & ~reg_wdata[NBUF-1:0]) : '0;
  assign allow     = mode ? '1 : NBUF'(1);
  assign rx_ready  = occ;

  always_comb begin
    occ_f = occ & ~free_mask;
    n_occ = '0;
    for (int i = 0; i < NBUF; i++) n_occ = n_occ + RANK_W'(occ_f[i]);
    for (int i = 0; i < NBUF; i++) begin
      rank_f[i] = '0;
      if (occ_f[i]) begin
        rank_f[i] = RANK_W'(1);
        for (int j = 0; j < NBUF; j++)
          if (occ_f[j] && rank[j] < rank[i]) rank_f[i] = rank_f[i] + RANK_W'(1);
      end
    end
    cand = ~occ_f & allow;
    slot = '0;
    has_slot = 1'b0;
    for (int i = NBUF - 1; i >= 0; i--)
      if (cand[i]) begin
        has_slot = 1'b1;
        slot = SLOT_W'(i);
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) stg_cnt <= '0;
    else if (rx_valid) stg_cnt <= rx_eof ? '0 : fin_len;
  end

  always_ff @(posedge clk) begin
    if (rx_valid && room) stg[stg_cnt[IDX_W-1:0]] <= rx_byte;
  end

  always_ff @(posedge clk) begin
    for (int b = 0; b < NBUF; b++)
      if (take && slot == SLOT_W'(b))
        for (int k = 0; k < MAX_LEN; k++)
          mem[b][k] <= (room && stg_cnt == LEN_W'(k)) ? rx_byte : stg[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ   <= '0;
      rank  <= '0;
      len   <= '0;
      clr_q <= '0;
      mode  <= 1'b0;
      ovf   <= 1'b0;
    end else begin
      occ  <= occ_f;
      rank <= rank_f;
      if (take) begin
        occ[slot]  <= 1'b1;
        rank[slot] <= n_occ + RANK_W'(1);
        len[slot]  <= fin_len;
      end
      if (ctrl_wr) begin
        clr_q <= reg_wdata[NBUF-1:0];
        mode  <= reg_wdata[MODE_BIT];
      end
      if (drop) ovf <= 1'b1;
      else if (ctrl_wr && reg_wdata[OVF_BIT]) ovf <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int b = 0; b < NBUF; b++) begin
      if (reg_addr >= AW'(b * MAX_LEN) && reg_addr < AW'((b + 1) * MAX_LEN) &&
          occ[b] && LEN_W'(reg_addr[IDX_W-1:0]) < len[b])
        reg_rdata = mem[b][reg_addr[IDX_W-1:0]];
      if (reg_addr == AW'(LEN_BASE + b) && occ[b])
        reg_rdata = DW'(len[b]);
    end
    if (reg_addr == AW'(STAT_ADDR))
      for (int b = 0; b < NBUF; b++) reg_rdata[2*b +: 2] = rank[b];
    if (reg_addr == AW'(CTRL_ADDR))
      reg_rdata = DW'({ovf, mode, clr_q});
  end
endmodule

// File: rtl/cec_rx_tribuf_chk.sv
module cec_rx_tribuf_chk #(
  parameter int NBUF    = 3,
  parameter int MAX_LEN = 16,
  parameter int LEN_W   = 5
) (
  input logic clk,
  input logic rst_n,
  input logic [NBUF-1:0] rx_ready,
  input logic [NBUF-1:0][1:0] rank,
  input logic [NBUF-1:0][LEN_W-1:0] len,
  input logic mode,
  input logic ovf
);
  for (genvar i = 0; i < NBUF; i++) begin : g_buf
    assert_ready_rank_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rx_ready[i] == (rank[i] != 2'd0));
    assert_len_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rx_ready[i] |-> (len[i] != '0 && len[i] <= LEN_W'(MAX_LEN)));
    assert_rank_contig_R4: assert property (@(posedge clk) disable iff (!rst_n)
      int'(rank[i]) <= $countones(rx_ready));
    for (genvar j = i + 1; j < NBUF; j++) begin : g_pair
      assert_rank_unique_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rank[i] != 2'd0 && rank[j] != 2'd0) |-> rank[i] != rank[j]);
    end
    if (i > 0) begin : g_leg
      assert_legacy_buf0_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_ready[i]) |-> $past(mode));
    end
  end
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> ($past(mode) ? $past(&rx_ready) : $past(rx_ready[0])));
endmodule

bind cec_rx_tribuf cec_rx_tribuf_chk #(.NBUF(NBUF), .MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .rx_ready(rx_ready), .rank(rank), .len(len),
  .mode(mode), .ovf(ovf));

// File: tb/cec_rx_tribuf_tb_top.sv
module cec_rx_tribuf_tb_top;
  localparam logic [5:0] STAT = 6'h33, CTRL = 6'h34;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_valid = 1'b0, rx_eof = 1'b0, reg_we = 1'b0;
  logic [7:0] rx_byte = '0, reg_wdata = '0, reg_rdata;
  logic [5:0] reg_addr = '0;
  logic [2:0] rx_ready;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  cec_rx_tribuf dut_i (.clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_eof(rx_eof), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .rx_ready(rx_ready));

  task automatic check(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
    end
  endtask

  task automatic rd(logic [5:0] a, string req, logic [7:0] exp);
    reg_addr = a;
    #1;
    check(req, reg_rdata, exp);
  endtask

  task automatic wr(logic [5:0] a, logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic send(int n, logic [7:0] seed);
    for (int k = 0; k < n; k++) begin
      rx_valid = 1'b1; rx_byte = seed + 8'(k); rx_eof = (k == n - 1);
      @(negedge clk);
    end
    rx_valid = 1'b0; rx_eof = 1'b0;
  endtask

  task automatic t_reset();
    rd(STAT, "R11 status", 8'h00);
    rd(CTRL, "R11 ctrl", 8'h00);
    rd(6'h30, "R11 len0", 8'h00);
    check("R11 ready", {5'b0, rx_ready}, 8'h00);
  endtask

  task automatic t_fill();
    wr(CTRL, 8'h08);
    send(3, 8'h40); send(5, 8'h50); send(2, 8'h60);
    rd(STAT, "R4 ranks after fill", 8'h39);
    check("R10 ready all", {5'b0, rx_ready}, 8'h07);
    for (int k = 0; k < 5; k++) rd(6'h10 + 6'(k), "R1 buf1 byte", 8'h50 + 8'(k));
    rd(6'h00, "R1 buf0 header", 8'h40);
    rd(6'h31, "R2 len1", 8'h05);
    rd(6'h32, "R2 len2", 8'h02);
    rd(6'h15, "R12 past length", 8'h00);
  endtask

  task automatic t_overflow();
    send(4, 8'hC0);
    rd(CTRL, "R8 overflow set", 8'h18);
    rd(STAT, "R8 ranks kept", 8'h39);
    rd(6'h00, "R8 buf0 kept", 8'h40);
    rd(6'h30, "R8 len0 kept", 8'h03);
    wr(CTRL, 8'h18);
    rd(CTRL, "R8 overflow cleared", 8'h08);
  endtask

  task automatic t_release();
    wr(CTRL, 8'h09);
    check("R6 held while bit set", {5'b0, rx_ready}, 8'h07);
    rd(STAT, "R6 ranks while held", 8'h39);
    wr(CTRL, 8'h08);
    rd(STAT, "R5 oldest released", 8'h24);
    check("R10 ready after release", {5'b0, rx_ready}, 8'h06);
    rd(6'h00, "R12 empty buffer", 8'h00);
    send(1, 8'h70);
    rd(STAT, "R1 R4 refill slot0", 8'h27);
    rd(6'h00, "R1 refill byte", 8'h70);
    rd(6'h30, "R2 refill len", 8'h01);
    wr(CTRL, 8'h0C); wr(CTRL, 8'h08);
    rd(STAT, "R5 middle released", 8'h06);
  endtask

  task automatic t_truncate();
    send(20, 8'h80);
    rd(STAT, "R3 R4 rank of long frame", 8'h36);
    rd(6'h32, "R3 length capped", 8'h10);
    rd(6'h20, "R3 first byte", 8'h80);
    rd(6'h2F, "R3 last kept byte", 8'h8F);
  endtask

  task automatic t_clear_all();
    wr(CTRL, 8'h0F);
    check("R6 clear held", {5'b0, rx_ready}, 8'h07);
    wr(CTRL, 8'h08);
    rd(STAT, "R7 all empty", 8'h00);
    check("R7 ready none", {5'b0, rx_ready}, 8'h00);
    rd(CTRL, "R7 mode kept", 8'h08);
  endtask

  task automatic t_legacy();
    wr(CTRL, 8'h00);
    send(2, 8'h90);
    send(2, 8'hA0);
    check("R9 only buf0", {5'b0, rx_ready}, 8'h01);
    rd(STAT, "R9 status", 8'h01);
    rd(CTRL, "R9 drop flagged", 8'h10);
    rd(6'h00, "R9 buf0 kept", 8'h90);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill();
    t_overflow();
    t_release();
    t_truncate();
    t_clear_all();
    t_legacy();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule